// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block is the state machine inside a processor core that moves it between its run state and three low-power states: halt, stop-grant and sleep. A halt-instruction strobe from the core asks for halt. A level-sensitive stop-clock request from the system asks for stop-grant or sleep. A sleep qualifier, sampled when the stop-clock request is recognised, picks sleep. For each entry the block raises a special-bus-cycle request with its type. It lowers the core clock enable only after the bus acknowledges that cycle. The system clock itself is never gated; only the core clock enable is lowered.

Halt is left on any enabled wake event: INIT, NMI, SMI, or INTR while interrupts are enabled. The stop states are left only when the stop-clock request drops. Wake events that arrive in any low-power state are captured in sticky latches. On the return to the run state they are reported one at a time, as a one-hot cause, and each one is cleared by an acknowledge pulse. A one-cycle resume pulse marks the return from a stop state, where execution continues at the boundary where the request was recognised. The active-low reset, asynchronous, overrides everything.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the block is in the run state: core_clk_en_o=1, probe_ok_o=1, spc_req_o=0, spc_type_o=0, wake_valid_o=0, wake_cause_o=0, resume_o=0.
- R2: In the run state a halt_i strobe raises spc_req_o with spc_type_o=0 (halt). The request is held until spc_ack_i. On the edge that samples the acknowledge the request drops and core_clk_en_o goes to 0. core_clk_en_o never falls without an acknowledge.
- R3: In halt, INIT, NMI or SMI, or INTR with intr_en_i=1, sampled on an edge returns the block to the run state (core_clk_en_o=1) on that edge.
- R4: INTR with intr_en_i=0 neither wakes halt nor is latched as a wake cause.
- R5: A stop_clk_i recognised in the run state produces no request while bus_busy_i=1. On the first edge that samples bus_busy_i=0, spc_req_o=1 with spc_type_o=1 (stop-grant) appears.
- R6: The sleep_sel_i value sampled when stop_clk_i is recognised selects the state after the acknowledge. 0 gives stop-grant with probe_ok_o=1. 1 gives sleep with probe_ok_o=0. core_clk_en_o=0 in both.
- R7: In stop-grant or sleep the block stays put while stop_clk_i=1, whatever wake events arrive.
- R8: Wake events in any state other than run are latched. In the run state wake_valid_o=1 and wake_cause_o shows one latched event as a one-hot code: bit0 INIT, bit1 INTR, bit2 NMI, bit3 SMI. Priority is INIT, then NMI, then SMI, then INTR. A wake_ack_i pulse clears the shown event, and the next one is shown on the following cycle.
- R9: resume_o is high for exactly one cycle after a return from stop-grant or sleep, and stays low after a return from halt.
- R10: rst_ni low forces the run state at once from any state and clears every latched wake event.
- R11: If halt_i and stop_clk_i arrive together in the run state, the stop-clock request wins.
- R12: If stop_clk_i drops while bus cycles are still draining, the block returns to run without issuing any special cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, never gated |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Halt instruction strobe |
| stop_clk_i | input | 1 | Stop-clock request level |
| bus_busy_i | input | 1 | Pending or in-progress bus cycle |
| sleep_sel_i | input | 1 | Selects sleep instead of stop-grant |
| spc_ack_i | input | 1 | Bus acknowledge of the special cycle |
| init_i | input | 1 | INIT wake line |
| intr_i | input | 1 | Maskable interrupt line |
| intr_en_i | input | 1 | Interrupt enable flag |
| nmi_i | input | 1 | Non-maskable interrupt line |
| smi_i | input | 1 | System management interrupt line |
| wake_ack_i | input | 1 | Clears the reported wake cause |
| spc_req_o | output | 1 | Special-cycle request |
| spc_type_o | output | 1 | Special-cycle type: 0 halt, 1 stop-grant |
| probe_ok_o | output | 1 | Probes allowed |
| core_clk_en_o | output | 1 | Core clock enable |
| wake_valid_o | output | 1 | A wake cause is reported |
| wake_cause_o | output | 4 | One-hot wake cause |
| resume_o | output | 1 | Resume pulse after a stop state |

## Verification
Every output is decoded from registered state, so each result is due one clock edge after the stimulus that causes it. The only exception is reset, which acts at once. The bench changes inputs one time unit after a rising edge and reads the outputs one time unit after the next rising edge, so each table row checks exactly the effect of its own inputs. Multi-step effects, such as draining before a request or stepping through latched causes, are spread over consecutive rows, one edge per row. The reset checks sample while rst_ni is still low, with no edge in between.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [2:0] {
    PS_RUN, PS_HALT_REQ, PS_HALT, PS_DRAIN, PS_GRANT_REQ, PS_GRANT, PS_SLEEP
  } pstate_e;

  localparam int unsigned WAKE_NUM = 4;
  localparam int unsigned WAKE_IW  = $clog2(WAKE_NUM);
  typedef logic [WAKE_IW-1:0] wk_idx_t;

  localparam wk_idx_t WK_INIT = 2'd0;
  localparam wk_idx_t WK_INTR = 2'd1;
  localparam wk_idx_t WK_NMI  = 2'd2;
  localparam wk_idx_t WK_SMI  = 2'd3;

  // index 0 is the highest priority
  localparam wk_idx_t WAKE_PRIO [WAKE_NUM] = '{WK_INIT, WK_NMI, WK_SMI, WK_INTR};
endpackage

// File: rtl/pwr_wake_latch.sv
module pwr_wake_latch
  import pwr_state_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic                present_i,
  input  logic [WAKE_NUM-1:0] ev_i,
  input  logic                ack_i,
  output logic                valid_o,
  output logic [WAKE_NUM-1:0] cause_o,
  output logic                pend_any_o
);
  logic [WAKE_NUM-1:0] pend_q;
  logic [WAKE_NUM-1:0] top_sel;
  logic                clear;

  assign clear = present_i & ack_i;

  for (genvar g = 0; g < WAKE_NUM; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     pend_q[g] <= 1'b0;
      else if (capture_i && ev_i[g])   pend_q[g] <= 1'b1;
      else if (clear && cause_o[g])    pend_q[g] <= 1'b0;
    end
  end

  always_comb begin
    top_sel = '0;
    for (int k = WAKE_NUM - 1; k >= 0; k--) begin
      if (pend_q[WAKE_PRIO[k]]) begin
        top_sel = '0;
        top_sel[WAKE_PRIO[k]] = 1'b1;
      end
    end
  end

  assign pend_any_o = |pend_q;
  assign valid_o    = present_i & pend_any_o;
  assign cause_o    = valid_o ? top_sel : '0;

  assert_cause_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(cause_o) == 1);

  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ack_i && !capture_i) |=> ((pend_q & $past(cause_o)) == '0));

  assert_run_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && !(valid_o && ack_i)) |=> $stable(pend_q));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_state_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    halt_i,
  input  logic    stop_i,
  input  logic    busy_i,
  input  logic    sleep_sel_i,
  input  logic    ack_i,
  input  logic    wake_i,
  input  logic    pend_any_i,
  output pstate_e state_o,
  output logic    resume_o
);
  pstate_e state_q, state_d;
  logic    deep_q;
  logic    resume_q;
  logic    in_stop;

  assign in_stop = (state_q == PS_GRANT) || (state_q == PS_SLEEP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:       if (stop_i) state_d = PS_DRAIN;
                    else if (halt_i) state_d = PS_HALT_REQ;
      PS_HALT_REQ:  if (ack_i) state_d = PS_HALT;
      PS_HALT:      if (wake_i || pend_any_i) state_d = PS_RUN;
      PS_DRAIN:     if (!stop_i) state_d = PS_RUN;
                    else if (!busy_i) state_d = PS_GRANT_REQ;
      PS_GRANT_REQ: if (ack_i) state_d = deep_q ? PS_SLEEP : PS_GRANT;
      PS_GRANT,
      PS_SLEEP:     if (!stop_i) state_d = PS_RUN;
      default:      state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PS_RUN;
      deep_q   <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= in_stop && !stop_i;
      if (state_q == PS_RUN && stop_i) deep_q <= sleep_sel_i;
    end
  end

  assign state_o  = state_q;
  assign resume_o = resume_q;

  assert_req_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_HALT_REQ && !ack_i) |=> state_q == PS_HALT_REQ);

  assert_drain_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_DRAIN && busy_i) |=> state_q != PS_GRANT_REQ);

  assert_stop_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_stop && stop_i) |=> $stable(state_q));

  assert_stop_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_RUN && stop_i) |=> state_q == PS_DRAIN);

  assert_abort_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_DRAIN && !stop_i) |=> state_q == PS_RUN);
endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
  import pwr_state_pkg::*;
(
  input  pstate_e state_i,
  output logic    spc_req_o,
  output logic    spc_type_o,
  output logic    probe_ok_o,
  output logic    clk_en_o
);
  always_comb begin
    spc_req_o  = 1'b0;
    spc_type_o = 1'b0;
    probe_ok_o = 1'b1;
    clk_en_o   = 1'b1;
    unique case (state_i)
      PS_HALT_REQ:  spc_req_o = 1'b1;
      PS_GRANT_REQ: begin spc_req_o = 1'b1; spc_type_o = 1'b1; end
      PS_HALT,
      PS_GRANT:     clk_en_o = 1'b0;
      PS_SLEEP:     begin clk_en_o = 1'b0; probe_ok_o = 1'b0; end
      default:      ;
    endcase
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                halt_i,
  input  logic                stop_clk_i,
  input  logic                bus_busy_i,
  input  logic                sleep_sel_i,
  input  logic                spc_ack_i,
  input  logic                init_i,
  input  logic                intr_i,
  input  logic                intr_en_i,
  input  logic                nmi_i,
  input  logic                smi_i,
  input  logic                wake_ack_i,
  output logic                spc_req_o,
  output logic                spc_type_o,
  output logic                probe_ok_o,
  output logic                core_clk_en_o,
  output logic                wake_valid_o,
  output logic [WAKE_NUM-1:0] wake_cause_o,
  output logic                resume_o
);
  pstate_e             state;
  logic [WAKE_NUM-1:0] ev;
  logic                pend_any;
  logic                in_run;

  always_comb begin
    ev          = '0;
    ev[WK_INIT] = init_i;
    ev[WK_INTR] = intr_i & intr_en_i;
    ev[WK_NMI]  = nmi_i;
    ev[WK_SMI]  = smi_i;
  end

  assign in_run = (state == PS_RUN);

  pwr_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_i      (halt_i),
    .stop_i      (stop_clk_i),
    .busy_i      (bus_busy_i),
    .sleep_sel_i (sleep_sel_i),
    .ack_i       (spc_ack_i),
    .wake_i      (|ev),
    .pend_any_i  (pend_any),
    .state_o     (state),
    .resume_o    (resume_o)
  );

  pwr_wake_latch u_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (!in_run),
    .present_i  (in_run),
    .ev_i       (ev),
    .ack_i      (wake_ack_i),
    .valid_o    (wake_valid_o),
    .cause_o    (wake_cause_o),
    .pend_any_o (pend_any)
  );

  pwr_out_dec u_dec (
    .state_i    (state),
    .spc_req_o  (spc_req_o),
    .spc_type_o (spc_type_o),
    .probe_ok_o (probe_ok_o),
    .clk_en_o   (core_clk_en_o)
  );

  assert_gate_after_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_clk_en_o) |-> $past(spc_ack_i) && $past(spc_req_o));

  assert_masked_intr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PS_HALT && !init_i && !nmi_i && !smi_i && !intr_en_i && !pend_any)
      |=> state == PS_HALT);

  assert_resume_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);

  assert_halt_wake_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PS_HALT && (init_i || nmi_i || smi_i || (intr_i && intr_en_i)))
      |=> core_clk_en_o);
endmodule

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;
  localparam logic [9:0] DEF = 10'b0_0_1_1_0_0000_0;

  // {req tag[24:21], inputs[20:10] halt stop busy sel ack init intr ien nmi smi wack,
  //  expected[9:0] req typ probe clken wvalid cause[3:0] resume}
  localparam logic [24:0] VEC [NVEC] = '{
    {4'd2,  11'b1_0_0_0_0_0_0_0_0_0_0, 10'b1_0_1_1_0_0000_0}, // R2 halt request
    {4'd2,  11'b0_0_0_0_0_0_0_0_0_0_0, 10'b1_0_1_1_0_0000_0}, // R2 held
    {4'd2,  11'b0_0_0_0_1_0_0_0_0_0_0, 10'b0_0_1_0_0_0000_0}, // R2 gated after ack
    {4'd4,  11'b0_0_0_0_0_0_1_0_0_0_0, 10'b0_0_1_0_0_0000_0}, // R4 masked INTR
    {4'd3,  11'b0_0_0_0_0_0_0_0_1_0_0, 10'b0_0_1_1_1_0100_0}, // R3 NMI wakes
    {4'd8,  11'b0_0_0_0_0_0_0_0_0_0_1, DEF},                   // R8 ack clears
    {4'd5,  11'b0_1_1_0_0_0_0_0_0_0_0, DEF},                   // R5 drain
    {4'd5,  11'b0_1_1_0_0_0_0_0_0_0_0, DEF},                   // R5 still busy
    {4'd5,  11'b0_1_0_0_0_0_0_0_0_0_0, 10'b1_1_1_1_0_0000_0}, // R5 grant request
    {4'd6,  11'b0_1_0_0_1_0_0_0_0_0_0, 10'b0_0_1_0_0_0000_0}, // R6 stop-grant
    {4'd7,  11'b0_1_0_0_0_1_0_0_0_1_0, 10'b0_0_1_0_0_0000_0}, // R7 INIT+SMI latched
    {4'd7,  11'b0_1_0_0_0_0_1_1_0_0_0, 10'b0_0_1_0_0_0000_0}, // R7 INTR latched
    {4'd9,  11'b0_0_0_0_0_0_0_0_0_0_0, 10'b0_0_1_1_1_0001_1}, // R9 resume, R8 INIT first
    {4'd8,  11'b0_0_0_0_0_0_0_0_0_0_1, 10'b0_0_1_1_1_1000_0}, // R8 SMI next
    {4'd8,  11'b0_0_0_0_0_0_0_0_0_0_1, 10'b0_0_1_1_1_0010_0}, // R8 INTR last
    {4'd8,  11'b0_0_0_0_0_0_0_0_0_0_1, DEF},                   // R8 empty
    {4'd6,  11'b0_1_0_1_0_0_0_0_0_0_0, DEF},                   // R6 sleep selected
    {4'd6,  11'b0_1_0_0_0_0_0_0_0_0_0, 10'b1_1_1_1_0_0000_0}, // R6 request
    {4'd6,  11'b0_1_0_0_1_0_0_0_0_0_0, 10'b0_0_0_0_0_0000_0}, // R6 sleep, no probes
    {4'd9,  11'b0_0_0_0_0_0_0_0_0_0_0, 10'b0_0_1_1_0_0000_1}, // R9 resume
    {4'd11, 11'b1_1_1_0_0_0_0_0_0_0_0, DEF},                   // R11 stop wins
    {4'd12, 11'b0_0_0_0_0_0_0_0_0_0_0, DEF},                   // R12 abort drain
    {4'd12, 11'b0_0_0_0_0_0_0_0_0_0_0, DEF},                   // R12 no request
    {4'd2,  11'b1_0_0_0_0_0_0_0_0_0_0, 10'b1_0_1_1_0_0000_0}, // R2 halt again
    {4'd2,  11'b0_0_0_0_1_0_0_0_0_0_0, 10'b0_0_1_0_0_0000_0}, // R2 gated
    {4'd3,  11'b0_0_0_0_0_0_1_1_0_0_0, 10'b0_0_1_1_1_0010_0}, // R3 INTR wakes, R9 no resume
    {4'd8,  11'b0_0_0_0_0_0_0_0_0_0_1, DEF}                    // R8 clear
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic halt_i, stop_clk_i, bus_busy_i, sleep_sel_i, spc_ack_i;
  logic init_i, intr_i, intr_en_i, nmi_i, smi_i, wake_ack_i;
  logic spc_req_o, spc_type_o, probe_ok_o, core_clk_en_o, wake_valid_o, resume_o;
  logic [3:0] wake_cause_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .halt_i(halt_i), .stop_clk_i(stop_clk_i),
    .bus_busy_i(bus_busy_i), .sleep_sel_i(sleep_sel_i), .spc_ack_i(spc_ack_i),
    .init_i(init_i), .intr_i(intr_i), .intr_en_i(intr_en_i), .nmi_i(nmi_i),
    .smi_i(smi_i), .wake_ack_i(wake_ack_i), .spc_req_o(spc_req_o),
    .spc_type_o(spc_type_o), .probe_ok_o(probe_ok_o), .core_clk_en_o(core_clk_en_o),
    .wake_valid_o(wake_valid_o), .wake_cause_o(wake_cause_o), .resume_o(resume_o)
  );

  function automatic logic [9:0] outs();
    return {spc_req_o, spc_type_o, probe_ok_o, core_clk_en_o, wake_valid_o,
            wake_cause_o, resume_o};
  endfunction

  task automatic drive(input logic [10:0] v);
    {halt_i, stop_clk_i, bus_busy_i, sleep_sel_i, spc_ack_i,
     init_i, intr_i, intr_en_i, nmi_i, smi_i, wake_ack_i} = v;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: outputs got %b expected %b", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    drive('0);
    #(CLK_PERIOD * 2 + 3);
    check(1, outs(), DEF); // R1 during reset
    rst_ni = 1'b1;
    cyc();
    check(1, outs(), DEF); // R1 after release

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][20:10]);
      cyc();
      check(int'(VEC[i][24:21]), outs(), VEC[i][9:0]);
    end

    // R10: async reset out of sleep with a latched event
    drive(11'b0_1_0_1_0_0_0_0_0_0_0); cyc();
    drive(11'b0_1_0_0_0_0_0_0_0_0_0); cyc();
    drive(11'b0_1_0_0_1_0_0_0_0_0_0); cyc();
    drive(11'b0_1_0_0_0_0_0_0_1_0_0); cyc();
    check(10, outs(), 10'b0_0_0_0_0_0000_0); // in sleep, NMI latched
    #2 rst_ni = 1'b0;
    #1 check(10, outs(), DEF);               // immediate, no edge
    drive('0);
    cyc();
    rst_ni = 1'b1;
    cyc();
    check(10, outs(), DEF);                  // latch cleared, no cause shown
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule